// File: doc/BRIEF.md
# Translation Status and Instruction Trace Registers

This block keeps the status and trace state of an address-translation unit. It has three registers. The first is the status word. It holds the translation enable bit and records the last fault: which abort cause fired, the run mode, whether the access used the data space, and the page number. The second is a delta log. It records the register number and the signed step of each auto-increment or auto-decrement made by the current instruction, and it keeps the most recent two. The third is a start-address register. It captures the program counter at the start of each instruction.

When a fault is recorded, one of the three abort-cause bits is set. Any nonzero abort-cause bit freezes the register set. From then on, new faults are not recorded, the delta log is not updated and the start address is not updated. The freeze holds until software rewrites the status word, so a fault handler always reads the state of the first failing access. The translator reports faults, the sequencer sends instruction-start and trap-entry strobes, and the address-mode logic supplies the log entries. Software reaches all three registers through a small register port. Reads are whole words, and the status word accepts byte-enabled writes.

Top module: `mm_status_unit`

## Requirements
- R1: Bits 11 and 10 of the status word always read as zero, whatever value is written.
- R2: When the value to be stored by a status write has bit 0 (enable) set, its bits 15:13 are stored as zero.
- R3: When the register set is locked and the value to be stored by a status write has bit 0 clear, only bits 7:1 of that value are kept and every other bit is stored as zero.
- R4: A status write uses bus_sel=0 and bus_be. bus_be[0] selects bits 7:0 and bus_be[1] selects bits 15:8. Bytes that are not enabled keep their old value, and R1 to R3 are applied to the merged word. A write with bus_be=0 does nothing.
- R5: flt_cause 1, 2 and 3 mean not resident, length error and read-only; 0 means no fault. When a fault arrives and the set is unlocked, the block clears bits 15:13 and 6:1. It then sets bit 15, 14 or 13 for cause 1, 2 or 3, writes flt_mode into bits 6:5, flt_dspace into bit 4 and flt_page into bits 3:1. All other bits keep their value. If a status write arrives in the same cycle, the fault takes priority and the write is dropped.
- R6: The set is locked whenever any of status bits 15:13 is set, and regs_locked shows this. While locked, faults are ignored, insn_start and log_valid have no effect, and a status write from the bus is still applied.
- R7: When insn_start is high and the set is unlocked, the delta log is cleared and the start-address register loads insn_pc.
- R8: When log_valid is high and the set is unlocked, the delta log shifts left by 8. The 5-bit two's-complement log_delta, which lies between -2 and +2, goes into bits 7:3 and log_reg goes into bits 2:0. If insn_start is high in the same cycle, the log holds only the new entry.
- R9: trap_entry clears the delta log even while locked. It takes priority over insn_start and log_valid, which are then dropped for the log.
- R10: Reset clears all three registers. A read with bus_sel 0, 1 or 2 returns the status word, the delta log or the start address, and bus_sel 3 returns zero. Writes with bus_sel 1 to 3 have no effect.
- R11: xlate_en always equals status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register select: 0 status, 1 delta log, 2 start address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register, combinational |
| flt_cause | input | 2 | Fault cause from the translator, 0 when idle |
| flt_mode | input | 2 | Run mode of the faulting access |
| flt_dspace | input | 1 | Faulting access used the data space |
| flt_page | input | 3 | Page number of the faulting access |
| insn_start | input | 1 | Instruction start strobe |
| insn_pc | input | 16 | Start address of the instruction |
| trap_entry | input | 1 | Trap entry strobe |
| log_valid | input | 1 | Register change log strobe |
| log_delta | input | 5 | Signed register step, -2 to +2 |
| log_reg | input | 3 | Number of the changed register |
| xlate_en | output | 1 | Translation enable (status bit 0) |
| regs_locked | output | 1 | Abort-cause freeze active |

## Verification
If the lock flag is wrong, the effect shows on the cycle after the next instruction start or log entry. Either the start address or the delta log moves when it should hold, or holds when it should move. If the status word merge or masking is wrong, a read at the next falling edge returns a bad value. The error then spreads, because whether the set is locked depends on bits 15:13. A delta log with the wrong shift or field placement gives a bad read after the second entry of an instruction, since the first entry must show up unchanged in the upper byte.

// File: rtl/mm_status_pkg.sv
package mm_status_pkg;
  parameter int unsigned WORD_W  = 16;
  parameter int unsigned MODE_W  = 2;
  parameter int unsigned PAGE_W  = 3;
  parameter int unsigned DELTA_W = 5;
  parameter int unsigned REGN_W  = 3;
  localparam int unsigned ENTRY_W = DELTA_W + REGN_W;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_NONRES = 2'd1,
    FLT_LENGTH = 2'd2,
    FLT_RDONLY = 2'd3
  } flt_cause_e;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_DLOG   = 2'd1,
    SEL_SPC    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Merge the enabled bytes, then apply the fixed-zero, enable and lock rules
  function automatic logic [WORD_W-1:0] status_masked_write(
    input logic [WORD_W-1:0] old_v,
    input logic [WORD_W-1:0] wdata,
    input logic [1:0]        be,
    input logic              lk
  );
    logic [WORD_W-1:0] m;
    m[7:0]  = be[0] ? wdata[7:0]  : old_v[7:0];
    m[15:8] = be[1] ? wdata[15:8] : old_v[15:8];
    m[11:10] = 2'b00;
    if (m[0])
      m[15:13] = 3'b000;
    else if (lk)
      m = m & 16'h00FE;
    return m;
  endfunction

  // Record a fault: one abort-cause bit plus the mode, space and page fields
  function automatic logic [WORD_W-1:0] status_fault(
    input logic [WORD_W-1:0] old_v,
    input flt_cause_e        cause,
    input logic [MODE_W-1:0] mode,
    input logic              dsp,
    input logic [PAGE_W-1:0] page
  );
    logic [WORD_W-1:0] v;
    v = old_v;
    v[15:13] = 3'b000;
    v[6:1]   = 6'b0;
    case (cause)
      FLT_NONRES: v[15] = 1'b1;
      FLT_LENGTH: v[14] = 1'b1;
      FLT_RDONLY: v[13] = 1'b1;
      default:    ;
    endcase
    v[6:5] = mode;
    v[4]   = dsp;
    v[3:1] = page;
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] dlog_push(
    input logic [WORD_W-1:0]  old_v,
    input logic [DELTA_W-1:0] delta,
    input logic [REGN_W-1:0]  regn
  );
    return {old_v[WORD_W-ENTRY_W-1:0], delta, regn};
  endfunction
endpackage

// File: rtl/mm_status_word.sv
module mm_status_word
  import mm_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  flt_cause_e        flt_cause,
  input  logic [MODE_W-1:0] flt_mode,
  input  logic              flt_dspace,
  input  logic [PAGE_W-1:0] flt_page,
  output logic [WORD_W-1:0] status_q,
  output logic              locked
);
  logic fault_take;
  logic write_take;

  assign locked     = |status_q[15:13];
  assign fault_take = (flt_cause != FLT_NONE) && !locked;
  assign write_take = wr_en && !fault_take;

  always_ff @(posedge clk) begin
    if (!rst_n)
      status_q <= '0;
    else if (fault_take)
      status_q <= status_fault(status_q, flt_cause, flt_mode, flt_dspace, flt_page);
    else if (write_take)
      status_q <= status_masked_write(status_q, wr_data, wr_be, locked);
  end

  // R1
  fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[11:10] == 2'b00);

  // R2
  enable_clears_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_take && wr_be == 2'b11 && wr_data[0] |=> status_q[15:13] == 3'b000);

  // R5
  fault_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> $countones(status_q[15:13]) == 1 &&
                   status_q[6:5] == $past(flt_mode) &&
                   status_q[3:1] == $past(flt_page));

  // R6
  frozen_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && flt_cause != FLT_NONE && !wr_en |=> $stable(status_q));
endmodule

// File: rtl/mm_delta_log.sv
module mm_delta_log
  import mm_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_entry,
  input  logic               insn_start,
  input  logic               log_valid,
  input  logic [DELTA_W-1:0] log_delta,
  input  logic [REGN_W-1:0]  log_reg,
  input  logic               locked,
  output logic [WORD_W-1:0]  dlog_q
);
  logic              push_take;
  logic              clear_take;
  logic [WORD_W-1:0] base_v;

  assign clear_take = trap_entry || (insn_start && !locked);
  assign push_take  = log_valid && !locked && !trap_entry;
  assign base_v     = (insn_start && !locked) ? '0 : dlog_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      dlog_q <= '0;
    else if (push_take)
      dlog_q <= dlog_push(base_v, log_delta, log_reg);
    else if (clear_take)
      dlog_q <= '0;
  end

  // R9
  trap_clears_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_entry |=> dlog_q == '0);

  // R6
  frozen_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !trap_entry |=> $stable(dlog_q));

  // R8
  shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_take && !insn_start |=> dlog_q[15:8] == $past(dlog_q[7:0]));

  // R8
  delta_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> ($signed(log_delta) >= -5'sd2 && $signed(log_delta) <= 5'sd2));
endmodule

// File: rtl/mm_start_pc.sv
module mm_start_pc
  import mm_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_start,
  input  logic [WORD_W-1:0] insn_pc,
  input  logic              locked,
  output logic [WORD_W-1:0] spc_q
);
  logic load_take;
  assign load_take = insn_start && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n)
      spc_q <= '0;
    else if (load_take)
      spc_q <= insn_pc;
  end

  // R7
  pc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_take |=> spc_q == $past(insn_pc));

  // R6
  frozen_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(spc_q));
endmodule

// File: rtl/mm_status_unit.sv
module mm_status_unit
  import mm_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_sel,
  input  logic               bus_wr,
  input  logic [1:0]         bus_be,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic [1:0]         flt_cause,
  input  logic [MODE_W-1:0]  flt_mode,
  input  logic               flt_dspace,
  input  logic [PAGE_W-1:0]  flt_page,
  input  logic               insn_start,
  input  logic [WORD_W-1:0]  insn_pc,
  input  logic               trap_entry,
  input  logic               log_valid,
  input  logic [DELTA_W-1:0] log_delta,
  input  logic [REGN_W-1:0]  log_reg,
  output logic               xlate_en,
  output logic               regs_locked
);
  logic [WORD_W-1:0] status_q;
  logic [WORD_W-1:0] dlog_q;
  logic [WORD_W-1:0] spc_q;
  logic              locked;
  logic              status_wr;
  reg_sel_e          sel;

  assign sel       = reg_sel_e'(bus_sel);
  assign status_wr = bus_wr && (sel == SEL_STATUS) && (bus_be != 2'b00);

  mm_status_word u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (status_wr),
    .wr_be      (bus_be),
    .wr_data    (bus_wdata),
    .flt_cause  (flt_cause_e'(flt_cause)),
    .flt_mode   (flt_mode),
    .flt_dspace (flt_dspace),
    .flt_page   (flt_page),
    .status_q   (status_q),
    .locked     (locked)
  );

  mm_delta_log u_dlog (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_entry (trap_entry),
    .insn_start (insn_start),
    .log_valid  (log_valid),
    .log_delta  (log_delta),
    .log_reg    (log_reg),
    .locked     (locked),
    .dlog_q     (dlog_q)
  );

  mm_start_pc u_spc (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_start (insn_start),
    .insn_pc    (insn_pc),
    .locked     (locked),
    .spc_q      (spc_q)
  );

  always_comb begin
    case (sel)
      SEL_STATUS: bus_rdata = status_q;
      SEL_DLOG:   bus_rdata = dlog_q;
      SEL_SPC:    bus_rdata = spc_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign xlate_en    = status_q[0];
  assign regs_locked = locked;

  // R10
  idle_sel_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_NONE |-> bus_rdata == '0);
endmodule

// File: tb/mm_status_unit_tb.sv
module mm_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_sel = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  flt_cause = '0;
  logic [1:0]  flt_mode = '0;
  logic        flt_dspace = 1'b0;
  logic [2:0]  flt_page = '0;
  logic        insn_start = 1'b0;
  logic [15:0] insn_pc = '0;
  logic        trap_entry = 1'b0;
  logic        log_valid = 1'b0;
  logic [4:0]  log_delta = '0;
  logic [2:0]  log_reg = '0;
  logic        xlate_en;
  logic        regs_locked;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  logic [15:0] m_stat = '0, m_log = '0, m_pc = '0;

  always #5 clk = ~clk;

  mm_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flt_cause(flt_cause),
    .flt_mode(flt_mode), .flt_dspace(flt_dspace), .flt_page(flt_page),
    .insn_start(insn_start), .insn_pc(insn_pc), .trap_entry(trap_entry),
    .log_valid(log_valid), .log_delta(log_delta), .log_reg(log_reg),
    .xlate_en(xlate_en), .regs_locked(regs_locked)
  );

  function automatic logic [15:0] exp_write(input logic [15:0] old_v, input logic [15:0] wd,
                                            input logic [1:0] be, input bit lk);
    logic [15:0] keep, v;
    keep = {{8{be[1]}}, {8{be[0]}}};
    v = (wd & keep) | (old_v & ~keep);
    v = v & ~16'h0C00;
    if (v[0]) v = v & 16'h1FFF;
    else if (lk) v = v & 16'h00FE;
    return v;
  endfunction

  function automatic logic [15:0] exp_fault(input logic [15:0] old_v, input logic [1:0] c,
                                            input logic [1:0] md, input logic d, input logic [2:0] pg);
    logic [15:0] v;
    v = old_v & 16'h1F81;
    v = v | (16'h8000 >> (c - 2'd1));
    v = v | {9'b0, md, d, pg, 1'b0};
    return v;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    bus_sel = 2'd0; #1; cmp(tag, "status", bus_rdata, m_stat);
    bus_sel = 2'd1; #1; cmp(tag, "delta log", bus_rdata, m_log);
    bus_sel = 2'd2; #1; cmp(tag, "start pc", bus_rdata, m_pc);
    bus_sel = 2'd3; #1; cmp({tag, " R10"}, "unused sel", bus_rdata, 16'h0);
    cmp({tag, " R11"}, "xlate_en", {15'b0, xlate_en}, {15'b0, m_stat[0]});
    cmp({tag, " R6"}, "regs_locked", {15'b0, regs_locked}, {15'b0, |m_stat[15:13]});
  endtask

  task automatic idle();
    bus_wr = 0; bus_be = 0; flt_cause = 0; insn_start = 0;
    trap_entry = 0; log_valid = 0;
  endtask

  task automatic tick(input string tag);
    logic [15:0] ns, nl, np;
    bit lk;
    lk = (m_stat[15:13] != 3'b000);
    ns = m_stat;
    if (flt_cause != 2'd0 && !lk) ns = exp_fault(m_stat, flt_cause, flt_mode, flt_dspace, flt_page);
    else if (bus_wr && bus_sel == 2'd0 && bus_be != 2'b00) ns = exp_write(m_stat, bus_wdata, bus_be, lk);
    nl = m_log;
    if (trap_entry) nl = 16'h0;
    else if (!lk) begin
      if (insn_start) nl = 16'h0;
      if (log_valid) nl = {nl[7:0], log_delta, log_reg};
    end
    np = (!lk && insn_start) ? insn_pc : m_pc;
    @(posedge clk);
    m_stat = ns; m_log = nl; m_pc = np;
    @(negedge clk);
    check_all(tag);
    idle();
  endtask

  task automatic wr_status(input logic [15:0] d, input logic [1:0] be, input string tag);
    bus_wr = 1; bus_sel = 2'd0; bus_be = be; bus_wdata = d;
    tick(tag);
  endtask

  task automatic fault(input logic [1:0] c, input logic [1:0] md, input logic d,
                       input logic [2:0] pg, input string tag);
    flt_cause = c; flt_mode = md; flt_dspace = d; flt_page = pg;
    tick(tag);
  endtask

  task automatic log_one(input int dl, input logic [2:0] r, input string tag);
    log_valid = 1; log_delta = 5'(dl); log_reg = r;
    tick(tag);
  endtask

  task automatic start(input logic [15:0] pc, input string tag);
    insn_start = 1; insn_pc = pc;
    tick(tag);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R10 reset");

    // R1 R2: all ones with enable set
    wr_status(16'hFFFF, 2'b11, "R1 R2 full write");
    // R3: lock, then locked write with bit 0 clear
    wr_status(16'hE0FE, 2'b11, "R1 lock by write");
    fault(2'd1, 2'd3, 1'b1, 3'd7, "R6 fault ignored when locked");
    start(16'h4444, "R6 start ignored when locked");
    log_one(1, 3'd2, "R6 log ignored when locked");
    wr_status(16'hFFFE, 2'b11, "R3 locked write keeps 7:1");
    // R4 byte writes
    wr_status(16'hA500, 2'b10, "R4 high byte");
    wr_status(16'h003C, 2'b01, "R4 low byte");
    wr_status(16'hFFFF, 2'b00, "R4 no byte enables");
    // R10 writes to other selects ignored
    bus_wr = 1; bus_sel = 2'd1; bus_be = 2'b11; bus_wdata = 16'h5A5A; tick("R10 write sel 1 ignored");
    bus_wr = 1; bus_sel = 2'd2; bus_be = 2'b11; bus_wdata = 16'h5A5A; tick("R10 write sel 2 ignored");
    wr_status(16'h0001, 2'b11, "R11 enable on");
    // R7 R8 two-entry log
    start(16'h1234, "R7 start capture");
    log_one(-2, 3'd6, "R8 first entry");
    log_one(1, 3'd3, "R8 second entry");
    log_one(2, 3'd1, "R8 third entry drops oldest");
    insn_start = 1; insn_pc = 16'h2000; log_valid = 1; log_delta = 5'h1F; log_reg = 3'd4;
    tick("R8 start with log same cycle");
    // R9 trap priority
    trap_entry = 1; insn_start = 1; insn_pc = 16'h3000; log_valid = 1; log_delta = 5'd1; log_reg = 3'd5;
    tick("R9 trap over start and log");
    // R5 each cause, fault over same-cycle write
    fault(2'd1, 2'd0, 1'b0, 3'd1, "R5 nonresident");
    wr_status(16'h0001, 2'b11, "R2 unlock via enable");
    log_one(-1, 3'd7, "R8 log after unlock");
    fault(2'd2, 2'd3, 1'b1, 3'd5, "R5 length");
    log_one(1, 3'd0, "R6 log frozen");
    trap_entry = 1; tick("R9 trap clears while locked");
    wr_status(16'h0000, 2'b11, "R3 unlock via clear");
    bus_wr = 1; bus_sel = 2'd0; bus_be = 2'b11; bus_wdata = 16'h0001;
    flt_cause = 2'd3; flt_mode = 2'd1; flt_dspace = 1'b0; flt_page = 3'd2;
    tick("R5 read-only beats write");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bus_wr = ($urandom % 3) == 0;
      bus_sel = 2'($urandom);
      bus_be = 2'($urandom);
      bus_wdata = 16'($urandom);
      flt_cause = (($urandom % 4) == 0) ? 2'($urandom) : 2'd0;
      flt_mode = 2'($urandom);
      flt_dspace = 1'($urandom);
      flt_page = 3'($urandom);
      insn_start = ($urandom % 4) == 0;
      insn_pc = 16'($urandom);
      trap_entry = ($urandom % 16) == 0;
      log_valid = ($urandom % 3) == 0;
      log_delta = 5'(int'($urandom % 5) - 2);
      log_reg = 3'($urandom);
      tick("R4 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule